// File: doc/BRIEF.md
# PCI Transaction Phase Tracker

This block listens to the control wires of a conventional PCI bus and reports where the current bus transaction stands. It never drives the bus. It does not look at the address, command or data wires. On every rising clock edge it samples the active-low frame, initiator-ready, target-ready, stop and device-select lines. It then updates a small phase register and a set of flags. Each output reflects the edge just sampled and is valid for the whole following clock period.

A transaction starts when the frame line is seen asserted while the tracker is idle. That edge is the address phase. Every later edge at which the frame line or the initiator-ready line is still asserted is a data-phase edge. On such an edge the block does three things:
- It reports a completed transfer when both ready lines are asserted.
- It counts a wait state otherwise.
- It marks the final data phase when frame has dropped but initiator-ready is still held.

The tracker returns to idle on the edge where frame and initiator-ready are both released. It also watches for a missing device-select response, which is the master-abort case.

The outputs can qualify a parity checker, a bus trace recorder or a protocol monitor.

Top module: `pci_phase_tracker`

## Requirements
- R1: After `rst_n` goes low, asynchronously, and until the first edge that sees frame asserted, `bus_idle`=1. In that state `addr_phase`, `data_phase`, `xfer_done`, `last_phase`, `claimed`, `target_stop` and `master_abort` are 0 and `wait_count` is 0. At any time exactly one of `bus_idle`, `addr_phase`, `data_phase` is 1.
- R2: When the tracker is idle and `frame_n` is sampled low, `addr_phase` is 1 for exactly the following clock. On the next edge the tracker moves to `data_phase`=1.
- R3: A data-phase edge is any edge, after the address edge, at which `frame_n` or `irdy_n` is low. `data_phase` stays 1 through such edges. The tracker returns to `bus_idle`=1 after the first edge in a transaction with both `frame_n` and `irdy_n` high.
- R4: `xfer_done` is 1 for exactly one clock after each data-phase edge at which `irdy_n` and `trdy_n` are both low. It is 0 after every other edge.
- R5: `last_phase` is 1 after a data-phase edge with `frame_n` high and `irdy_n` low. It is 0 after every other edge.
- R6: `wait_count` (8 bits by default) is cleared at the address edge. It increases by one on each data-phase edge at which `irdy_n` or `trdy_n` is high. It stops at 255 and holds its value after the transaction ends.
- R7: `claimed` equals the inverse of `devsel_n` as sampled at the previous edge.
- R8: `target_stop` is 1 after an edge inside a transaction (address or data phase) at which `stop_n` is low. A low `stop_n` sampled while idle leaves it at 0.
- R9: `master_abort` becomes 1 after the fifth edge that follows the address edge if `devsel_n` was high at all five of those edges. `devsel_n` low at any one of those edges prevents it. Once set, it holds until the next address edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge samples |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| frame_n | input | 1 | Frame line, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Device select, active low |
| bus_idle | output | 1 | No transaction in progress |
| addr_phase | output | 1 | Address phase just sampled |
| data_phase | output | 1 | Transaction in its data phases |
| xfer_done | output | 1 | One-clock pulse per completed data phase |
| last_phase | output | 1 | Final data phase in progress |
| claimed | output | 1 | A target asserted device select |
| target_stop | output | 1 | Target requested termination |
| master_abort | output | 1 | No device select within the response window |
| wait_count | output | WAIT_W | Saturating wait-state count of the current or last transaction |

## Verification
The hardest state to reach from the ports is a saturated wait counter. It needs a single transaction with more than 255 stalled data-phase edges. The bench gets there by holding frame and initiator-ready asserted with target-ready released for 300 edges, checking both below and at saturation. It then starts a new transaction to see the clear. The master-abort window is also checked at its exact edge, in two ways: device select is withheld for all five edges, and in a second run it arrives on the fifth edge itself, which must still prevent the abort.

// File: rtl/pci_phase_tracker.sv
module pci_phase_tracker #(
  parameter int WAIT_W      = 8,
  parameter int ABORT_LIMIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  input  logic              devsel_n,
  output logic              bus_idle,
  output logic              addr_phase,
  output logic              data_phase,
  output logic              xfer_done,
  output logic              last_phase,
  output logic              claimed,
  output logic              target_stop,
  output logic              master_abort,
  output logic [WAIT_W-1:0] wait_count
);

  localparam int AC_W = $clog2(ABORT_LIMIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;
  localparam logic [AC_W-1:0]   AC_LAST  = AC_W'(ABORT_LIMIT - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;

  phase_e ph, ph_nxt;
  logic [AC_W-1:0] ab_cnt;
  logic            sel_seen;

  logic frame, irdy, trdy, stop, devsel;
  assign frame  = ~frame_n;
  assign irdy   = ~irdy_n;
  assign trdy   = ~trdy_n;
  assign stop   = ~stop_n;
  assign devsel = ~devsel_n;

  logic in_xact, start, data_edge, stall;
  assign in_xact   = (ph != PH_IDLE);
  assign start     = (ph == PH_IDLE) && frame;
  assign data_edge = in_xact && (frame || irdy);
  assign stall     = data_edge && !(irdy && trdy);

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE: if (frame) ph_nxt = PH_ADDR;
      PH_ADDR: ph_nxt = (frame || irdy) ? PH_DATA : PH_IDLE;
      PH_DATA: if (!frame && !irdy) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      xfer_done   <= 1'b0;
      last_phase  <= 1'b0;
      claimed     <= 1'b0;
      target_stop <= 1'b0;
    end else begin
      ph          <= ph_nxt;
      xfer_done   <= data_edge && irdy && trdy;
      last_phase  <= data_edge && !frame && irdy;
      claimed     <= devsel;
      target_stop <= (in_xact || start) && stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_count <= '0;
    end else if (start) begin
      wait_count <= '0;
    end else if (stall && wait_count != WAIT_MAX) begin
      wait_count <= wait_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_cnt       <= '0;
      sel_seen     <= 1'b0;
      master_abort <= 1'b0;
    end else if (start) begin
      ab_cnt       <= '0;
      sel_seen     <= 1'b0;
      master_abort <= 1'b0;
    end else if (in_xact && !sel_seen && !master_abort) begin
      if (devsel)
        sel_seen <= 1'b1;
      else if (ab_cnt == AC_LAST)
        master_abort <= 1'b1;
      else
        ab_cnt <= ab_cnt + 1'b1;
    end
  end

  assign bus_idle   = (ph == PH_IDLE);
  assign addr_phase = (ph == PH_ADDR);
  assign data_phase = (ph == PH_DATA);

endmodule

module pci_phase_tracker_chk #(
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              bus_idle,
  input logic              addr_phase,
  input logic              data_phase,
  input logic              xfer_done,
  input logic              master_abort,
  input logic [WAIT_W-1:0] wait_count
);

  p_one_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bus_idle, addr_phase, data_phase}) == 1);

  p_addr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> !addr_phase);

  p_idle_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && frame_n && irdy_n) |=> bus_idle);

  p_done_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> data_phase);

  p_wait_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_count == {WAIT_W{1'b1}}) |=> (wait_count == {WAIT_W{1'b1}}) || addr_phase);

  p_abort_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> !master_abort);

endmodule

bind pci_phase_tracker pci_phase_tracker_chk #(.WAIT_W(WAIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .bus_idle(bus_idle), .addr_phase(addr_phase), .data_phase(data_phase),
  .xfer_done(xfer_done), .master_abort(master_abort), .wait_count(wait_count)
);

// File: tb/pci_phase_tracker_tb.sv
module pci_phase_tracker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
  logic bus_idle, addr_phase, data_phase, xfer_done, last_phase;
  logic claimed, target_stop, master_abort;
  logic [7:0] wait_count;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_phase_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n),
    .bus_idle(bus_idle), .addr_phase(addr_phase), .data_phase(data_phase),
    .xfer_done(xfer_done), .last_phase(last_phase), .claimed(claimed),
    .target_stop(target_stop), .master_abort(master_abort),
    .wait_count(wait_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic i, input logic t, input logic s, input logic d);
    frame_n = !f; irdy_n = !i; trdy_n = !t; stop_n = !s; devsel_n = !d;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 idle", bus_idle, 1);
    chk("R1 addr", addr_phase, 0);
    chk("R1 data", data_phase, 0);
    chk("R1 flags", {xfer_done, last_phase, claimed, target_stop, master_abort}, 0);
    chk("R1 wait", wait_count, 0);
  endtask

  task automatic t_single_read;
    cyc(1,0,0,0,0);
    chk("R2 addr_phase", addr_phase, 1);
    chk("R1 idle low", bus_idle, 0);
    cyc(0,1,0,0,1);
    chk("R2 then data", data_phase, 1);
    chk("R5 last", last_phase, 1);
    chk("R6 wait one", wait_count, 1);
    chk("R7 claimed", claimed, 1);
    chk("R4 no done", xfer_done, 0);
    cyc(0,1,1,0,1);
    chk("R4 done", xfer_done, 1);
    chk("R6 no stall", wait_count, 1);
    cyc(0,0,0,0,0);
    chk("R3 idle", bus_idle, 1);
    chk("R4 pulse end", xfer_done, 0);
    chk("R7 released", claimed, 0);
    chk("R6 hold", wait_count, 1);
  endtask

  task automatic t_burst;
    int n = 0;
    cyc(1,0,0,0,0);
    for (int k = 0; k < 3; k++) begin
      cyc(1,1,1,0,1);
      n += xfer_done;
      chk("R5 not last", last_phase, 0);
      chk("R3 data", data_phase, 1);
    end
    cyc(0,1,1,0,1);
    n += xfer_done;
    chk("R5 last", last_phase, 1);
    cyc(0,0,0,0,0);
    chk("R4 four transfers", n, 4);
    chk("R6 no waits", wait_count, 0);
    chk("R3 idle", bus_idle, 1);
  endtask

  task automatic t_stop;
    cyc(0,0,0,1,0);
    chk("R8 idle stop ignored", target_stop, 0);
    chk("R3 stays idle", bus_idle, 1);
    cyc(1,0,0,0,0);
    cyc(1,1,0,1,1);
    chk("R8 stop", target_stop, 1);
    cyc(0,1,0,1,1);
    chk("R8 stop held", target_stop, 1);
    chk("R5 last", last_phase, 1);
    cyc(0,0,0,0,0);
    chk("R8 stop gone", target_stop, 0);
  endtask

  task automatic t_abort;
    cyc(1,0,0,0,0);
    for (int k = 0; k < 4; k++) begin
      cyc(1,1,0,0,0);
      chk("R9 not yet", master_abort, 0);
    end
    cyc(0,1,0,0,0);
    chk("R9 abort", master_abort, 1);
    cyc(0,0,0,0,0);
    chk("R9 held", master_abort, 1);
    cyc(1,0,0,0,0);
    chk("R9 cleared", master_abort, 0);
    for (int k = 0; k < 4; k++) cyc(1,1,0,0,0);
    cyc(0,1,1,0,1);
    chk("R9 late select", master_abort, 0);
    chk("R4 done", xfer_done, 1);
    cyc(0,0,0,0,0);
    chk("R9 still clear", master_abort, 0);
  endtask

  task automatic t_saturate;
    cyc(1,0,0,0,0);
    for (int k = 1; k <= 300; k++) begin
      cyc(1,1,0,0,1);
      if (k == 10) chk("R6 counting", wait_count, 10);
    end
    chk("R6 saturated", wait_count, 255);
    cyc(0,1,1,0,1);
    chk("R6 sat hold", wait_count, 255);
    cyc(0,0,0,0,0);
    cyc(1,0,0,0,0);
    chk("R6 cleared", wait_count, 0);
    cyc(0,1,1,0,1);
    cyc(0,0,0,0,0);
  endtask

  task automatic t_reset_mid;
    cyc(1,0,0,0,0);
    cyc(1,1,0,1,1);
    rst_n = 1'b0;
    #1;
    chk("R1 async idle", bus_idle, 1);
    chk("R1 async flags", {target_stop, claimed}, 0);
    frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1; devsel_n = 1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", bus_idle, 1);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_single_read;
    t_burst;
    t_stop;
    t_abort;
    t_saturate;
    t_reset_mid;
    finish_run;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule